// File: doc/BRIEF.md
# BCD Clock and Calendar Counter

This block keeps wall-clock time and a calendar date in binary-coded decimal registers: seconds, minutes, hours, day of week, day of month, month with a century flag, and a two-digit year. A free-running enable `tick_i` at 32.768 kHz feeds a sub-second prescaler. Once every `PRESCALE` ticks, that prescaler advances the time by one second. All carries, up to the year and century, settle in that single clock cycle.

A host sets and reads the registers through a plain parallel port with a 3-bit register index. The read data is registered. Hours are kept in 24-hour form or in a packed 12-hour form, where bit 5 marks the afternoon, as selected by `hour_24h_i`. Month lengths follow the month, and February gets its 29th day whenever the two year digits are divisible by four. Writing the seconds register restarts the prescaler, so the next second boundary is a full `PRESCALE` ticks after the write.

Top module: `rtc_calendar`

## Requirements
- R1: After synchronous reset the registers hold 00 seconds, 00 minutes, midnight (0x00 in 24-hour mode, 0x12 in 12-hour mode), day of week 0, day 0x01, month 0x01 with century bit 0, year 0x00, and `rdata_o` reads 0x00.
- R2: `rdata_o` shows, one clock after an edge, the register that `addr_i` selected at that edge, taken before that edge's update. The index map is: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month (bit 7 century, bits 4:0 month), 6 year. Index 7 reads 0x00.
- R3: Bits with no meaning ignore writes and read as 0. The stored bits are 0x7F (seconds), 0x7F (minutes), 0x3F (hours), 0x07 (day of week), 0x3F (day of month), 0x9F (month), and 0xFF (year).
- R4: Seconds and minutes count 00 to 59 in BCD. From 59 they return to 00 and carry into the next register.
- R5: With `hour_24h_i`=1, hours count 0x00 to 0x23. From 0x23 they wrap to 0x00 and advance the date.
- R6: With `hour_24h_i`=0, the hour sequence is 0x12 (midnight), 0x01 to 0x11, then 0x32 (noon), then 0x21 to 0x31. The step from 0x31 returns to 0x12 and advances the date.
- R7: On each date advance, day of week steps from 0 to 6. Any value of 6 or above returns to 0.
- R8: Day of month rolls back to 0x01 after its last day and advances the month. The last day is 28, or 29 in a year divisible by four, for February; 30 for months 0x04, 0x06, 0x09 and 0x11; and 31 otherwise. Month 0x12 advances to 0x01 and steps the year.
- R9: When the year steps from 0x99 to 0x00, the century bit inverts.
- R10: The time advances by one second on every `PRESCALE`-th asserted `tick_i`. A write to index 0 clears the prescaler count.
- R11: In a cycle with `wr_en_i` high, the written register takes `wdata_i`. Any one-second advance due in that cycle is dropped for every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 32.768 kHz enable, one cycle wide per tick |
| hour_24h_i | input | 1 | 1 selects 24-hour hours, 0 selects packed 12-hour hours |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register index for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
The bound checker watches several behaviours on every cycle. It checks the seconds wrap from 59. It checks the midnight wrap in 24-hour mode and the 0x11 to 0x32 noon step in 12-hour mode. It checks that day of week never leaves 0 to 6 after a date advance, and that the century bit only inverts when the year lands on 0x00. It also checks that a seconds write both loads the value and zeroes the prescaler, and that a write to any other register stops the seconds from advancing. Some behaviours need a sequence of writes before the boundary of interest, so only the bench's scenarios show them. These are month lengths across leap and non-leap Februaries, 30-day months, the December to January rollover, the masking of unused bits, and the exact tick count from a seconds write to the next second.

// File: rtl/rtc_calendar_pkg.sv
`timescale 1ns/1ps
package rtc_calendar_pkg;

  localparam int unsigned REG_COUNT = 7;

  typedef enum logic [2:0] {
    RA_SEC  = 3'd0,
    RA_MIN  = 3'd1,
    RA_HOUR = 3'd2,
    RA_DOW  = 3'd3,
    RA_DOM  = 3'd4,
    RA_MON  = 3'd5,
    RA_YEAR = 3'd6,
    RA_NONE = 3'd7
  } rtc_addr_e;

  // Decimal value of a two-digit BCD byte (tolerates non-BCD nibbles).
  function automatic logic [7:0] bcd_val(input logic [7:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  // Two-digit BCD encoding of a binary value below 100.
  function automatic logic [7:0] to_bcd(input logic [6:0] b);
    logic [3:0] tens;
    tens = 4'(b / 7'd10);
    return {tens, 4'(b - 7'(tens) * 7'd10)};
  endfunction

  // Next BCD value without wrap handling.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // Hour register to linear hour 0..23.
  function automatic logic [5:0] hour_to_lin(input logic [5:0] h, input logic m24);
    logic [5:0] v;
    if (m24) return 6'(bcd_val({2'b00, h}));
    v = 6'(bcd_val({3'b000, h[4:0]}));
    if (v == 6'd12) v = 6'd0;
    return h[5] ? v + 6'd12 : v;
  endfunction

  // Linear hour 0..23 to hour register encoding.
  function automatic logic [5:0] lin_to_hour(input logic [5:0] b, input logic m24);
    logic       pm;
    logic [5:0] v;
    if (m24) return 6'(to_bcd({1'b0, b}));
    pm = (b >= 6'd12);
    v  = pm ? b - 6'd12 : b;
    if (v == 6'd0) v = 6'd12;
    return {pm, 5'(to_bcd({1'b0, v}))};
  endfunction

  // Last day of a BCD month, leap when the year digits are a multiple of four.
  function automatic logic [7:0] days_in_month(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      return ((bcd_val(yr) % 8'd4) == 8'd0) ? 8'd29 : 8'd28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'd30;
      default:                    return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       tick_i,
  input  logic                       clear_i,
  output logic                       pulse_o,
  output logic [$clog2(DIV)-1:0]     count_o
);
  localparam int unsigned CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign pulse_o = tick_i && at_last;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/rtc_time_core.sv
`timescale 1ns/1ps
module rtc_time_core
  import rtc_calendar_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       mode24_i,
  input  logic       inc_i,
  input  logic       wr_sec_i,
  input  logic       wr_min_i,
  input  logic       wr_hour_i,
  input  logic [6:0] sec_wd_i,
  input  logic [6:0] min_wd_i,
  input  logic [5:0] hour_wd_i,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [5:0] hour_o,
  output logic       hour_step_o,
  output logic       day_step_o
);
  logic [6:0] sec_q, min_q;
  logic [5:0] hour_q;
  logic       sec_wrap, min_wrap, hour_wrap;
  logic       min_step;
  logic [5:0] hour_lin;

  assign sec_wrap  = bcd_val({1'b0, sec_q}) >= 8'd59;
  assign min_wrap  = bcd_val({1'b0, min_q}) >= 8'd59;
  assign hour_lin  = hour_to_lin(hour_q, mode24_i);
  assign hour_wrap = hour_lin >= 6'd23;

  assign min_step    = inc_i && sec_wrap;
  assign hour_step_o = min_step && min_wrap;
  assign day_step_o  = hour_step_o && hour_wrap;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sec_q <= '0;
    end else if (wr_sec_i) begin
      sec_q <= sec_wd_i;
    end else if (inc_i) begin
      sec_q <= sec_wrap ? '0 : 7'(bcd_inc({1'b0, sec_q}));
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      min_q <= '0;
    end else if (wr_min_i) begin
      min_q <= min_wd_i;
    end else if (min_step) begin
      min_q <= min_wrap ? '0 : 7'(bcd_inc({1'b0, min_q}));
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hour_q <= mode24_i ? 6'h00 : 6'h12;
    end else if (wr_hour_i) begin
      hour_q <= hour_wd_i;
    end else if (hour_step_o) begin
      hour_q <= lin_to_hour(hour_wrap ? 6'd0 : hour_lin + 6'd1, mode24_i);
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
endmodule

// File: rtl/rtc_date_core.sv
`timescale 1ns/1ps
module rtc_date_core
  import rtc_calendar_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       day_inc_i,
  input  logic       wr_dow_i,
  input  logic       wr_dom_i,
  input  logic       wr_mon_i,
  input  logic       wr_year_i,
  input  logic [2:0] dow_wd_i,
  input  logic [5:0] dom_wd_i,
  input  logic [4:0] mon_wd_i,
  input  logic       cen_wd_i,
  input  logic [7:0] year_wd_i,
  output logic [2:0] dow_o,
  output logic [5:0] dom_o,
  output logic [4:0] mon_o,
  output logic       century_o,
  output logic [7:0] year_o
);
  logic [2:0] dow_q;
  logic [5:0] dom_q;
  logic [4:0] mon_q;
  logic       cen_q;
  logic [7:0] year_q;

  logic [7:0] last_day;
  logic       dom_wrap, mon_wrap, year_wrap, dow_wrap;
  logic       mon_inc, year_inc;

  assign last_day  = days_in_month(mon_q, year_q);
  assign dom_wrap  = bcd_val({2'b00, dom_q}) >= last_day;
  assign mon_wrap  = bcd_val({3'b000, mon_q}) >= 8'd12;
  assign year_wrap = bcd_val(year_q) >= 8'd99;
  assign dow_wrap  = dow_q >= 3'd6;

  assign mon_inc  = day_inc_i && dom_wrap;
  assign year_inc = mon_inc && mon_wrap;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dow_q <= '0;
    end else if (wr_dow_i) begin
      dow_q <= dow_wd_i;
    end else if (day_inc_i) begin
      dow_q <= dow_wrap ? 3'd0 : dow_q + 3'd1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dom_q <= 6'h01;
    end else if (wr_dom_i) begin
      dom_q <= dom_wd_i;
    end else if (day_inc_i) begin
      dom_q <= dom_wrap ? 6'h01 : 6'(bcd_inc({2'b00, dom_q}));
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mon_q <= 5'h01;
      cen_q <= 1'b0;
    end else if (wr_mon_i) begin
      mon_q <= mon_wd_i;
      cen_q <= cen_wd_i;
    end else begin
      if (mon_inc) mon_q <= mon_wrap ? 5'h01 : 5'(bcd_inc({3'b000, mon_q}));
      if (year_inc && year_wrap) cen_q <= ~cen_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      year_q <= '0;
    end else if (wr_year_i) begin
      year_q <= year_wd_i;
    end else if (year_inc) begin
      year_q <= year_wrap ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign dow_o     = dow_q;
  assign dom_o     = dom_q;
  assign mon_o     = mon_q;
  assign century_o = cen_q;
  assign year_o    = year_q;
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_calendar_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       tick_i,
  input  logic       hour_24h_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  localparam int unsigned CNT_W = $clog2(PRESCALE);

  logic [REG_COUNT-1:0] wr_sel;
  logic                 sec_pulse;
  logic                 inc;
  logic [CNT_W-1:0]     presc_cnt;

  logic [6:0] sec_q, min_q;
  logic [5:0] hour_q;
  logic       hour_step, day_step;
  logic [2:0] dow_q;
  logic [5:0] dom_q;
  logic [4:0] mon_q;
  logic       century_q;
  logic [7:0] year_q;
  logic [7:0] rd_mux;
  logic [7:0] rdata_q;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_wsel
    assign wr_sel[g] = wr_en_i && (addr_i == 3'(g));
  end

  // A write cycle swallows the one-second advance.
  assign inc = sec_pulse && !wr_en_i;

  rtc_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_i  (tick_i),
    .clear_i (wr_sel[RA_SEC]),
    .pulse_o (sec_pulse),
    .count_o (presc_cnt)
  );

  rtc_time_core u_time (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .mode24_i    (hour_24h_i),
    .inc_i       (inc),
    .wr_sec_i    (wr_sel[RA_SEC]),
    .wr_min_i    (wr_sel[RA_MIN]),
    .wr_hour_i   (wr_sel[RA_HOUR]),
    .sec_wd_i    (wdata_i[6:0]),
    .min_wd_i    (wdata_i[6:0]),
    .hour_wd_i   (wdata_i[5:0]),
    .sec_o       (sec_q),
    .min_o       (min_q),
    .hour_o      (hour_q),
    .hour_step_o (hour_step),
    .day_step_o  (day_step)
  );

  rtc_date_core u_date (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .day_inc_i (day_step),
    .wr_dow_i  (wr_sel[RA_DOW]),
    .wr_dom_i  (wr_sel[RA_DOM]),
    .wr_mon_i  (wr_sel[RA_MON]),
    .wr_year_i (wr_sel[RA_YEAR]),
    .dow_wd_i  (wdata_i[2:0]),
    .dom_wd_i  (wdata_i[5:0]),
    .mon_wd_i  (wdata_i[4:0]),
    .cen_wd_i  (wdata_i[7]),
    .year_wd_i (wdata_i),
    .dow_o     (dow_q),
    .dom_o     (dom_q),
    .mon_o     (mon_q),
    .century_o (century_q),
    .year_o    (year_q)
  );

  always_comb begin
    case (rtc_addr_e'(addr_i))
      RA_SEC:  rd_mux = {1'b0, sec_q};
      RA_MIN:  rd_mux = {1'b0, min_q};
      RA_HOUR: rd_mux = {2'b00, hour_q};
      RA_DOW:  rd_mux = {5'b00000, dow_q};
      RA_DOM:  rd_mux = {2'b00, dom_q};
      RA_MON:  rd_mux = {century_q, 2'b00, mon_q};
      RA_YEAR: rd_mux = year_q;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= 8'h00;
    else       rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk #(
  parameter int unsigned PRESCALE = 32768
) (
  input logic                        clk_i,
  input logic                        rst_i,
  input logic                        hour_24h_i,
  input logic                        wr_en_i,
  input logic [2:0]                  addr_i,
  input logic [7:0]                  wdata_i,
  input logic                        sec_pulse,
  input logic [$clog2(PRESCALE)-1:0] presc_cnt,
  input logic [6:0]                  sec_q,
  input logic [5:0]                  hour_q,
  input logic                        hour_step,
  input logic                        day_step,
  input logic [2:0]                  dow_q,
  input logic                        century_q,
  input logic [7:0]                  year_q
);
  a_r4_sec_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    (sec_pulse && !wr_en_i && sec_q == 7'h59) |=> (sec_q == 7'h00));

  a_r5_midnight_24h: assert property (@(posedge clk_i) disable iff (rst_i)
    (hour_24h_i && hour_step && hour_q == 6'h23) |=> (hour_q == 6'h00));

  a_r6_noon_12h: assert property (@(posedge clk_i) disable iff (rst_i)
    (!hour_24h_i && hour_step && hour_q == 6'h11) |=> (hour_q == 6'h32));

  a_r7_dow_range: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(day_step) |-> (dow_q <= 3'd6));

  a_r9_century_flip: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(wr_en_i) && century_q != $past(century_q)) |-> (year_q == 8'h00));

  a_r10_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == 3'd0) |=> (presc_cnt == '0));

  a_r11_write_loads: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i == 3'd0) |=> (sec_q == $past(wdata_i[6:0])));

  a_r11_advance_dropped: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && addr_i != 3'd0 && sec_pulse) |=> $stable(sec_q));
endmodule

bind rtc_calendar rtc_calendar_chk #(.PRESCALE(PRESCALE)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .hour_24h_i (hour_24h_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .sec_pulse  (sec_pulse),
  .presc_cnt  (presc_cnt),
  .sec_q      (sec_q),
  .hour_q     (hour_q),
  .hour_step  (hour_step),
  .day_step   (day_step),
  .dow_q      (dow_q),
  .century_q  (century_q),
  .year_q     (year_q)
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       mode24 = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit chk_on = 0;
  bit done = 0;
  int cyc = 0;
  int tick_mode = 0;   // 0 off, 1 two of three cycles, 2 every cycle
  int rd_ptr = 0;

  // behavioural model state (register images)
  int m_sec, m_min, m_hour, m_dow, m_dom, m_mon, m_cen, m_year, m_pc;
  int exp_rd;

  always #4 clk = ~clk;

  rtc_calendar #(.PRESCALE(DIV)) u_dut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .hour_24h_i(mode24),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic int dec(int x); return (x / 16) * 10 + (x % 16); endfunction
  function automatic int enc(int n); return (n / 10) * 16 + (n % 10); endfunction

  function automatic int hour_lin(int r, bit m24);
    int v;
    if (m24) return dec(r);
    v = dec(r & 'h1F);
    if (v == 12) v = 0;
    return v + (((r >> 5) & 1) ? 12 : 0);
  endfunction

  function automatic int hour_reg(int n, bit m24);
    int v;
    if (m24) return enc(n);
    v = n % 12;
    if (v == 0) v = 12;
    return enc(v) + ((n >= 12) ? 'h20 : 0);
  endfunction

  function automatic int month_days(int mon, int yr);
    case (dec(mon))
      2: return (dec(yr) % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic int model_read(int a);
    case (a)
      0: return m_sec;
      1: return m_min;
      2: return m_hour;
      3: return m_dow;
      4: return m_dom;
      5: return (m_cen << 7) | m_mon;
      6: return m_year;
      default: return 0;
    endcase
  endfunction

  task automatic model_day();
    m_dow = (m_dow >= 6) ? 0 : m_dow + 1;
    if (dec(m_dom) >= month_days(m_mon, m_year)) begin
      m_dom = 1;
      if (dec(m_mon) >= 12) begin
        m_mon = 1;
        if (dec(m_year) >= 99) begin
          m_year = 0;
          m_cen = 1 - m_cen;
        end else m_year = enc(dec(m_year) + 1);
      end else m_mon = enc(dec(m_mon) + 1);
    end else m_dom = enc(dec(m_dom) + 1);
  endtask

  task automatic model_second(bit m24);
    int h;
    if (dec(m_sec) < 59) begin m_sec = enc(dec(m_sec) + 1); return; end
    m_sec = 0;
    if (dec(m_min) < 59) begin m_min = enc(dec(m_min) + 1); return; end
    m_min = 0;
    h = hour_lin(m_hour, m24);
    if (h >= 23) begin
      m_hour = hour_reg(0, m24);
      model_day();
    end else m_hour = hour_reg(h + 1, m24);
  endtask

  always @(posedge clk) begin
    bit pulse;
    if (rst) begin
      exp_rd = 0;
      m_sec = 0; m_min = 0; m_hour = mode24 ? 'h00 : 'h12;
      m_dow = 0; m_dom = 1; m_mon = 1; m_cen = 0; m_year = 0; m_pc = 0;
    end else begin
      exp_rd = model_read(int'(addr));
      pulse = tick && (m_pc == DIV - 1);
      if (wr_en && addr == 3'd0) m_pc = 0;
      else if (tick) m_pc = pulse ? 0 : m_pc + 1;
      if (wr_en) begin
        case (addr)
          3'd0: m_sec  = wdata & 'h7F;
          3'd1: m_min  = wdata & 'h7F;
          3'd2: m_hour = wdata & 'h3F;
          3'd3: m_dow  = wdata & 'h07;
          3'd4: m_dom  = wdata & 'h3F;
          3'd5: begin m_mon = wdata & 'h1F; m_cen = (wdata >> 7) & 1; end
          3'd6: m_year = wdata;
          default: ;
        endcase
      end else if (pulse) model_second(mode24);
    end
    chk_on = 1;
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_cmp++;
      if (int'(rdata) != exp_rd) begin
        n_bad++;
        $display("FAIL %s: rdata=%02h expected=%02h (cycle %0d)", cur_req, rdata, exp_rd[7:0], cyc);
      end
    end
  end

  task automatic drive_tick();
    cyc++;
    case (tick_mode)
      1: tick = (cyc % 3) != 2;
      2: tick = 1'b1;
      default: tick = 1'b0;
    endcase
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      drive_tick();
      wr_en = 1'b0;
      addr = 3'(rd_ptr);
      rd_ptr = (rd_ptr + 1) % 8;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    drive_tick();
    wr_en = 1'b1;
    addr = 3'(a);
    wdata = 8'(d);
  endtask

  task automatic set_date(int yr, int mon, int dom, int hr, int mn, int sc);
    wr(6, yr); wr(5, mon); wr(4, dom); wr(2, hr); wr(1, mn); wr(0, sc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset values, ticks idle
    mode24 = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1"; idle(16);
    // R2: read map incl. index 7 with ticks running
    cur_req = "R2"; tick_mode = 1; idle(24);
    // R4: seconds/minutes carry
    cur_req = "R4"; set_date('h30, 'h05, 'h10, 'h07, 'h58, 'h55); idle(80);
    // R5: 24-hour midnight wrap
    cur_req = "R5"; set_date('h30, 'h05, 'h10, 'h23, 'h59, 'h57); idle(50);
    // R8: non-leap February, leap February, 30-day month
    cur_req = "R8"; set_date('h23, 'h02, 'h28, 'h23, 'h59, 'h58); idle(40);
    set_date('h24, 'h02, 'h28, 'h23, 'h59, 'h58); idle(40);
    wr(2, 'h23); wr(1, 'h59); wr(0, 'h58); idle(40);
    set_date('h24, 'h04, 'h30, 'h23, 'h59, 'h58); idle(40);
    set_date('h24, 'h07, 'h31, 'h23, 'h59, 'h58); idle(40);
    // R9: year rollover flips century both ways
    cur_req = "R9"; set_date('h99, 'h12, 'h31, 'h23, 'h59, 'h58); idle(40);
    set_date('h99, 'h92, 'h31, 'h23, 'h59, 'h58); idle(40);
    // R6: 12-hour encoding
    cur_req = "R6"; tick_mode = 0; idle(2); mode24 = 1'b0; tick_mode = 1;
    set_date('h25, 'h03, 'h05, 'h11, 'h59, 'h58); idle(40);
    wr(2, 'h32); wr(1, 'h59); wr(0, 'h58); idle(40);
    wr(2, 'h31); wr(1, 'h59); wr(0, 'h58); idle(40);
    wr(2, 'h12); wr(1, 'h59); wr(0, 'h58); idle(40);
    // R3: unused bits masked, ticks stopped
    cur_req = "R3"; tick_mode = 0; idle(2);
    for (int a = 0; a < 8; a++) wr(a, 'hFF);
    idle(16);
    // R7: day of week wrap from 6 and from masked 7
    cur_req = "R7"; mode24 = 1'b1;
    wr(3, 'h07); set_date('h25, 'h03, 'h05, 'h23, 'h59, 'h58); tick_mode = 1; idle(40);
    wr(3, 'h06); wr(2, 'h23); wr(1, 'h59); wr(0, 'h58); idle(40);
    // R10: seconds write restarts prescaler
    cur_req = "R10"; tick_mode = 2;
    wr(0, 'h10); idle(2); wr(0, 'h20); idle(3); wr(0, 'h30); idle(20);
    // R11: writes collide with second boundaries
    cur_req = "R11";
    for (int i = 0; i < 24; i++) wr(1, 'h15);
    for (int i = 0; i < 12; i++) begin wr(4, 'h07); idle(1); end
    idle(16);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule